// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block produces the serial clock for an I2C controller. It counts system-clock cycles for the low part and the high part of each SCL period. Three pairs of count values are provided, one pair for each speed class: standard, fast and high speed. A two-bit speed code picks one pair. The block only pulls SCL low. It never drives the line high. It watches the line through a synchronizer so that a target device holding SCL low stretches the period. Counting of the high part starts only after the line is seen high.

Two single-cycle strobes pace a bit engine. The change strobe marks the first cycle of each low part, when SDA may be changed. The sample strobe marks the middle of the counted high part, when SDA is read. The count values and the speed code are copied into holding registers only while the block is disabled. A running clock therefore keeps steady timing even when its configuration inputs move.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and for as long as `enable` is low, `scl_drive_low`, `sda_sample_stb` and `sda_change_stb` are all 0.
- R2: Speed code 0 selects the standard pair, code 1 selects the fast pair, code 2 selects the high-speed pair, and code 3 is treated as fast.
- R3: Each low part keeps `scl_drive_low` at 1 for exactly LO+1 consecutive cycles, where LO is the selected low count. Counting starts on the first cycle that SCL is driven low.
- R4: After the line is released, the block needs 3 cycles to see the line high. It then counts HI+8 cycles and drives the line low again. When nothing stretches the line, SCL is released for HI+11 cycles.
- R5: If a device holds SCL low for S cycles after release, the released time grows by exactly S cycles. The low part length stays the same.
- R6: `sda_sample_stb` pulses once per period, on released cycle S+3+((HI+8)>>1), counting from 0 at the first released cycle. It is only asserted while SCL is released and is seen high.
- R7: `sda_change_stb` pulses for one cycle, on the first cycle of every low part, and at no other time.
- R8: When the build parameter `HS_CAPABLE` is 0, speed code 2 uses the fast pair.
- R9: The counts and the speed code are captured only while `enable` is low. Changes made while enabled do not affect the running waveform.
- R10: One cycle after `enable` falls, SCL is released and both strobes stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the clock when high; loads the configuration when low |
| speed_sel | input | 2 | Speed code: 0 standard, 1 fast, 2 high speed, 3 fast |
| std_hi_cnt | input | CNT_W | Standard-mode high count |
| std_lo_cnt | input | CNT_W | Standard-mode low count |
| fast_hi_cnt | input | CNT_W | Fast-mode high count |
| fast_lo_cnt | input | CNT_W | Fast-mode low count |
| hspd_hi_cnt | input | CNT_W | High-speed-mode high count |
| hspd_lo_cnt | input | CNT_W | High-speed-mode low count |
| scl_in | input | 1 | Observed SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_sample_stb | output | 1 | One-cycle pulse in the middle of the high part |
| sda_change_stb | output | 1 | One-cycle pulse on the first cycle of the low part |

## Verification
The bench sweeps small low and high counts, including zero, across every speed code. The unselected pairs hold decoy values, so a faulty pair multiplexer shows up as wrong lengths. A design that checks the synchronized line only for high, without first seeing it low, reads the stale high value for tiny low counts and shortens the released time; the zero and one low-count cases catch this. Stretch runs with several hold lengths show whether stretching leaks into the low count or moves the sample strobe by the wrong amount. Further runs change the counts while enabled, drop `enable` in the middle of a period, and use a build without high speed. These show up a design that follows its inputs live, one that keeps driving after disable, and one that uses the high-speed pair when high speed is not built in.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

    typedef enum logic [1:0] {
        SPD_STD  = 2'd0,
        SPD_FAST = 2'd1,
        SPD_HIGH = 2'd2,
        SPD_RSVD = 2'd3
    } spd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } ph_e;

    // cycles added on top of the programmed high count
    localparam int HIGH_EXTRA = 8;

    // map the requested speed code onto the pair actually used
    function automatic spd_e eff_speed(input logic [1:0] code, input logic hs_ok);
        spd_e r;
        case (code)
            2'd0:    r = SPD_STD;
            2'd2:    r = hs_ok ? SPD_HIGH : SPD_FAST;
            default: r = SPD_FAST;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/scl_tg_cfg.sv
module scl_tg_cfg
    import scl_tg_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter bit HS_CAPABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [1:0]       speed_sel,
    input  logic [CNT_W-1:0] std_hi_cnt,
    input  logic [CNT_W-1:0] std_lo_cnt,
    input  logic [CNT_W-1:0] fast_hi_cnt,
    input  logic [CNT_W-1:0] fast_lo_cnt,
    input  logic [CNT_W-1:0] hspd_hi_cnt,
    input  logic [CNT_W-1:0] hspd_lo_cnt,
    output logic [CNT_W-1:0] act_hi,
    output logic [CNT_W-1:0] act_lo
);

    logic [CNT_W-1:0] pick_hi;
    logic [CNT_W-1:0] pick_lo;
    spd_e             spd;

    always_comb begin
        spd = eff_speed(speed_sel, HS_CAPABLE);
        case (spd)
            SPD_STD: begin
                pick_hi = std_hi_cnt;
                pick_lo = std_lo_cnt;
            end
            SPD_HIGH: begin
                pick_hi = hspd_hi_cnt;
                pick_lo = hspd_lo_cnt;
            end
            default: begin
                pick_hi = fast_hi_cnt;
                pick_lo = fast_lo_cnt;
            end
        endcase
    end

    // holding registers follow the inputs only while disabled
    always_ff @(posedge clk) begin
        if (rst) begin
            act_hi <= '0;
            act_lo <= '0;
        end else if (!enable) begin
            act_hi <= pick_hi;
            act_lo <= pick_lo;
        end
    end

endmodule

// File: rtl/scl_tg_sync.sv
module scl_tg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];

endmodule

// File: rtl/scl_tg_fsm.sv
module scl_tg_fsm
    import scl_tg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] act_hi,
    input  logic [CNT_W-1:0] act_lo,
    input  logic             scl_sync,
    output logic             drive_low,
    output logic             sample_stb,
    output logic             change_stb
);

    localparam int PW = CNT_W + 1;

    ph_e          ph;
    logic [PW-1:0] cnt;
    logic          seen_low;
    logic [PW-1:0] lo_last;
    logic [PW-1:0] hi_last;
    logic [PW-1:0] hi_mid;

    always_comb begin
        lo_last = {1'b0, act_lo};
        hi_last = {1'b0, act_hi} + PW'(HIGH_EXTRA - 1);
        hi_mid  = ({1'b0, act_hi} + PW'(HIGH_EXTRA)) >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            seen_low <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    ph       <= PH_LOW;
                    cnt      <= '0;
                    seen_low <= 1'b0;
                end
                PH_LOW: begin
                    if (!scl_sync) seen_low <= 1'b1;
                    if (cnt == lo_last) begin
                        ph  <= PH_WAIT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WAIT: begin
                    // high part begins only after a genuine low-to-high
                    if (seen_low && scl_sync) begin
                        ph       <= PH_HIGH;
                        cnt      <= '0;
                        seen_low <= 1'b0;
                    end else if (!scl_sync) begin
                        seen_low <= 1'b1;
                    end
                end
                default: begin
                    if (cnt == hi_last) begin
                        ph  <= PH_LOW;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign drive_low  = (ph == PH_LOW);
    assign change_stb = (ph == PH_LOW) && (cnt == '0);
    assign sample_stb = (ph == PH_HIGH) && (cnt == hi_mid);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter bit HS_CAPABLE  = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [1:0]       speed_sel,
    input  logic [CNT_W-1:0] std_hi_cnt,
    input  logic [CNT_W-1:0] std_lo_cnt,
    input  logic [CNT_W-1:0] fast_hi_cnt,
    input  logic [CNT_W-1:0] fast_lo_cnt,
    input  logic [CNT_W-1:0] hspd_hi_cnt,
    input  logic [CNT_W-1:0] hspd_lo_cnt,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             sda_sample_stb,
    output logic             sda_change_stb
);

    logic [CNT_W-1:0] act_hi;
    logic [CNT_W-1:0] act_lo;
    logic             scl_sync;

    scl_tg_cfg #(.CNT_W(CNT_W), .HS_CAPABLE(HS_CAPABLE)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .speed_sel   (speed_sel),
        .std_hi_cnt  (std_hi_cnt),
        .std_lo_cnt  (std_lo_cnt),
        .fast_hi_cnt (fast_hi_cnt),
        .fast_lo_cnt (fast_lo_cnt),
        .hspd_hi_cnt (hspd_hi_cnt),
        .hspd_lo_cnt (hspd_lo_cnt),
        .act_hi      (act_hi),
        .act_lo      (act_lo)
    );

    scl_tg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (scl_in),
        .dout (scl_sync)
    );

    scl_tg_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .act_hi     (act_hi),
        .act_lo     (act_lo),
        .scl_sync   (scl_sync),
        .drive_low  (scl_drive_low),
        .sample_stb (sda_sample_stb),
        .change_stb (sda_change_stb)
    );

endmodule

// File: rtl/scl_tg_checker.sv
module scl_tg_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             scl_drive_low,
    input logic             sda_sample_stb,
    input logic             sda_change_stb,
    input logic             scl_sync,
    input logic [CNT_W-1:0] act_hi,
    input logic [CNT_W-1:0] act_lo
);

    logic [CNT_W:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)                low_run <= '0;
        else if (scl_drive_low) low_run <= low_run + 1'b1;
        else                    low_run <= '0;
    end

    a_r10_disable_releases: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!scl_drive_low && !sda_sample_stb && !sda_change_stb));

    a_r7_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_drive_low) |-> sda_change_stb);

    a_r7_change_only_low: assert property (@(posedge clk) disable iff (rst)
        sda_change_stb |-> scl_drive_low);

    a_r6_sample_when_high: assert property (@(posedge clk) disable iff (rst)
        sda_sample_stb |-> (!scl_drive_low && scl_sync));

    a_r3_low_bounded: assert property (@(posedge clk) disable iff (rst)
        scl_drive_low |-> (low_run <= {1'b0, act_lo}));

    a_r9_frozen_cfg: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable)) |-> ($stable(act_hi) && $stable(act_lo)));

endmodule

bind scl_timing_gen scl_tg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .enable         (enable),
    .scl_drive_low  (scl_drive_low),
    .sda_sample_stb (sda_sample_stb),
    .sda_change_stb (sda_change_stb),
    .scl_sync       (scl_sync),
    .act_hi         (act_hi),
    .act_lo         (act_lo)
);

// File: tb/scl_timing_gen_bench.sv
`timescale 1ns/1ps
module scl_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [1:0]  speed_sel = 2'd0;
    logic [15:0] shi = '0, slo = '0, fhi = '0, flo = '0, hhi = '0, hlo = '0;
    logic        a_dl, a_smp, a_chg, b_dl, b_smp, b_chg;
    logic        scl_a, scl_b;
    int          stretch_len = 0;
    int          st_cnt = 0;
    bit          use_b = 1'b0;
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    // bus model: device may hold the line low after release
    always @(posedge clk) begin
        if (a_dl)            st_cnt <= stretch_len;
        else if (st_cnt > 0) st_cnt <= st_cnt - 1;
    end
    assign scl_a = !a_dl && (st_cnt == 0);
    assign scl_b = !b_dl;

    scl_timing_gen u_scl_timing_gen (
        .clk(clk), .rst(rst), .enable(enable), .speed_sel(speed_sel),
        .std_hi_cnt(shi), .std_lo_cnt(slo), .fast_hi_cnt(fhi), .fast_lo_cnt(flo),
        .hspd_hi_cnt(hhi), .hspd_lo_cnt(hlo), .scl_in(scl_a),
        .scl_drive_low(a_dl), .sda_sample_stb(a_smp), .sda_change_stb(a_chg)
    );

    scl_timing_gen #(.HS_CAPABLE(1'b0)) u_scl_timing_gen_nohs (
        .clk(clk), .rst(rst), .enable(enable), .speed_sel(speed_sel),
        .std_hi_cnt(shi), .std_lo_cnt(slo), .fast_hi_cnt(fhi), .fast_lo_cnt(flo),
        .hspd_hi_cnt(hhi), .hspd_lo_cnt(hlo), .scl_in(scl_b),
        .scl_drive_low(b_dl), .sda_sample_stb(b_smp), .sda_change_stb(b_chg)
    );

    wire m_dl  = use_b ? b_dl  : a_dl;
    wire m_smp = use_b ? b_smp : a_smp;
    wire m_chg = use_b ? b_chg : a_chg;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // measure one full period starting at a change strobe
    task automatic measure(output int low_n, output int rel_n, output int samp_at, output int samp_n);
        int guard;
        guard = 0;
        while (!m_chg && guard < 2000) begin @(negedge clk); guard++; end
        low_n = 0; rel_n = 0; samp_at = -1; samp_n = 0;
        while (m_dl && guard < 2000) begin low_n++; @(negedge clk); guard++; end
        while (!m_chg && guard < 2000) begin
            if (m_smp) begin samp_at = rel_n; samp_n++; end
            rel_n++; @(negedge clk); guard++;
        end
    endtask

    task automatic set_pairs(input int mode, input int h, input int l);
        shi = 16'(h + 5); slo = 16'(l + 7);
        fhi = 16'(h + 6); flo = 16'(l + 8);
        hhi = 16'(h + 7); hlo = 16'(l + 9);
        case (mode)
            0: begin shi = 16'(h); slo = 16'(l); end
            2: begin hhi = 16'(h); hlo = 16'(l); end
            default: begin fhi = 16'(h); flo = 16'(l); end
        endcase
        speed_sel = 2'(mode);
    endtask

    task automatic run_cfg(input string req, input int mode, input int h, input int l, input int s);
        int ln, rn, sa, sn;
        @(negedge clk);
        enable = 1'b0;
        set_pairs(mode, h, l);
        stretch_len = s;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        for (int p = 0; p < 2; p++) begin
            measure(ln, rn, sa, sn);
            chk({req, " R3 low length"}, ln, l + 1);
            chk({req, " R4 R5 released length"}, rn, s + 3 + h + 8);
            chk({req, " R6 sample position"}, sa, s + 3 + ((h + 8) >> 1));
            chk({req, " R6 sample count"}, sn, 1);
        end
        @(negedge clk);
        enable = 1'b0;
    endtask

    initial begin
        int ln, rn, sa, sn, idle_bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset while disabled
        idle_bad = 0;
        for (int i = 0; i < 6; i++) begin
            if (a_dl || a_smp || a_chg) idle_bad++;
            @(negedge clk);
        end
        chk("R1 idle outputs after reset", idle_bad, 0);

        // R2 R3 R4 R6 R7: sweep codes 0..2 and small counts
        for (int m = 0; m < 3; m++)
            for (int h = 0; h < 4; h++)
                for (int l = 0; l < 4; l++)
                    run_cfg("R2 sweep", m, h, l, 0);
        // R2: reserved code 3 acts as fast
        run_cfg("R2 code3", 3, 2, 5, 0);

        // R5: stretching
        for (int k = 0; k < 4; k++)
            run_cfg("R5 stretch", 1, 2, 1 + k, (k == 0) ? 1 : (k * 3));

        // R8: fallback build uses fast pair for code 2
        use_b = 1'b1;
        @(negedge clk);
        enable = 1'b0;
        stretch_len = 0;
        set_pairs(2, 1, 1);
        fhi = 16'd4; flo = 16'd3;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        measure(ln, rn, sa, sn);
        chk("R8 fallback low", ln, 4);
        chk("R8 fallback released", rn, 3 + 4 + 8);
        use_b = 1'b0;
        @(negedge clk);
        enable = 1'b0;

        // R9: changes while enabled are ignored
        @(negedge clk);
        set_pairs(0, 3, 2);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        measure(ln, rn, sa, sn);
        set_pairs(1, 9, 9);
        shi = 16'd20; slo = 16'd20;
        for (int p = 0; p < 2; p++) begin
            measure(ln, rn, sa, sn);
            chk("R9 frozen low", ln, 3);
            chk("R9 frozen released", rn, 3 + 3 + 8);
        end

        // R10: dropping enable mid-period releases the line
        repeat (4) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        idle_bad = 0;
        for (int i = 0; i < 10; i++) begin
            if (a_dl || a_smp || a_chg) idle_bad++;
            @(negedge clk);
        end
        chk("R10 released after disable", idle_bad, 0);

        // R7: first cycle after enable drives low with change strobe
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk("R7 change strobe at start", int'(a_chg), 1);
        chk("R7 drive low at start", int'(a_dl), 1);
        @(negedge clk);
        chk("R7 change strobe single", int'(a_chg), 0);
        enable = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule